// File: doc/BRIEF.md
# Character LCD Instruction Executor

This block is the command engine of a dot-matrix character display controller. It takes host transfers, which are instruction bytes or data bytes, and keeps the controller state. That state is the address counter, the RAM target, the entry mode, the display, cursor and blink flags, the display shift offset, and the line, font and bus-width modes. The block also drives the write and read strobes of an 80-byte display RAM and a 64-byte character RAM. After each data access it steps the address counter on its own.

Every accepted transfer holds a busy flag for a fixed number of oscillator cycles. Clear and home use a long window, and every other transfer uses a short one. The host either polls the busy output or waits out the window. A transfer that arrives while busy is dropped. Glyph lookup and panel drive belong to other blocks. Those blocks read the RAMs and the mode outputs.

Top module: `lcd_instr_exec`

## Requirements
- R1: Reset state. Address counter 0, display RAM targeted, shift offset 0, not busy. Display, cursor and blink are off. Entry mode is increment with no shift. The bus is 8-bit, one-line mode, short font. No RAM strobe is active.
- R2: An instruction byte (`host_rs`=0, `host_rw`=0) is decoded by its highest set bit, as follows.
  - Bit 0 alone: clear.
  - Bit 1: home.
  - Bit 2: entry mode (bit1 = increment, bit0 = shift on access).
  - Bit 3: display control (bit2 = display, bit1 = cursor, bit0 = blink).
  - Bit 4: shift (bit3 = display/cursor, bit2 = right).
  - Bit 5: function set (bit4 = 8-bit bus, bit3 = two lines, bit2 = tall font).
  - Bit 6: character RAM address (bits 5:0).
  - Bit 7: display RAM address (bits 6:0).
  - The byte 0x00 is ignored and does not set busy.
- R3: Clear writes the blank code 0x20 to every display RAM address, 0 to 79 in ascending order. It also sets the address counter to 0, the shift offset to 0 and the target to display RAM, and holds busy for BUSY_LONG cycles.
- R4: Home sets the address counter to 0, the shift offset to 0 and the target to display RAM. It writes no RAM and holds busy for BUSY_LONG cycles.
- R5: Entry mode, display control and function set load their fields onto the matching mode outputs.
- R6: An address-set instruction selects the RAM target and loads the address counter. A display RAM address at or above 80 is reduced modulo 80.
- R7: A data write (`host_rs`=1, `host_rw`=0) pulses the write strobe of the targeted RAM for one cycle. The strobe carries the address counter value from before the write and the host byte. The counter then steps by one: up when increment is set, down otherwise. It wraps modulo 80 for display RAM and modulo 64 for character RAM.
- R8: A data read (`host_rs`=1, `host_rw`=1) pulses the read strobe of the targeted RAM at the current address. The counter then steps the same way as in R7.
- R9: With shift-on-access set and display RAM targeted, each data access also moves the shift offset: +1 in increment mode, -1 in decrement mode.
- R10: The shift instruction acts on bit 3 and bit 2. With bit 3 = 0 it moves the address counter, +1 when bit 2 = 1 and -1 otherwise. With bit 3 = 1 it moves the shift offset, -1 for right (bit 2 = 1) and +1 for left.
- R11: The shift offset wraps modulo 40 in two-line mode and modulo 80 in one-line mode.
- R12: Busy rises in the cycle after a transfer is accepted. It stays high for BUSY_SHORT cycles for all transfers other than clear and home.
- R13: Transfers that arrive while busy change no state and produce no strobe. A status access (`host_rs`=0, `host_rw`=1) has no effect and does not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host transfer present this cycle |
| host_rs | input | 1 | 0 = instruction/status, 1 = data |
| host_rw | input | 1 | 0 = write, 1 = read |
| host_byte | input | 8 | Instruction or data byte |
| busy | output | 1 | Block is executing; transfers are ignored |
| ac | output | DD_AW | Address counter |
| target_cg | output | 1 | 1 = character RAM targeted |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| entry_inc | output | 1 | Address step direction, 1 = up |
| entry_shift | output | 1 | Shift display on each data access |
| bus_8bit | output | 1 | Host bus width mode |
| two_line | output | 1 | Two-line mode |
| font_tall | output | 1 | Tall font mode |
| shift_ofs | output | DD_AW | Display shift offset |
| dd_we | output | 1 | Display RAM write strobe |
| dd_re | output | 1 | Display RAM read strobe |
| dd_addr | output | DD_AW | Display RAM address |
| dd_wdata | output | 8 | Display RAM write data |
| cg_we | output | 1 | Character RAM write strobe |
| cg_re | output | 1 | Character RAM read strobe |
| cg_addr | output | CG_AW | Character RAM address |
| cg_wdata | output | 8 | Character RAM write data |

## Verification
The bench keeps the full 80-byte and 64-byte RAM depths. This exposes the real wrap points: 79 to 0 and 0 to 79 for display RAM, 63 to 0 for character RAM, 39 to 0 in two-line mode, and the modulo reduction of display RAM addresses above 79. It shortens the busy windows to BUSY_SHORT=3 and BUSY_LONG=90. With these values each window can be counted cycle by cycle, including the full 80-write clear sweep inside the long window, and a transfer can be placed inside a busy window to show that it is dropped.

// File: rtl/lcd_exec_pkg.sv
package lcd_exec_pkg;

   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_CLEAR = 4'd1,
      OP_HOME  = 4'd2,
      OP_ENTRY = 4'd3,
      OP_DISP  = 4'd4,
      OP_SHIFT = 4'd5,
      OP_FUNC  = 4'd6,
      OP_SETCG = 4'd7,
      OP_SETDD = 4'd8
   } op_e;

   localparam logic [7:0] BLANK_CODE = 8'h20;

   // one step up or down inside [0, m-1], wrapping at both ends
   function automatic logic [7:0] step_mod(input logic [7:0] v, input logic up,
                                           input logic [7:0] m);
      if (up)
         return (v + 8'd1 >= m) ? 8'd0 : v + 8'd1;
      else
         return (v == 8'd0 || v >= m) ? m - 8'd1 : v - 8'd1;
   endfunction

endpackage

// File: rtl/lcd_op_decode.sv
module lcd_op_decode
   import lcd_exec_pkg::*;
(
   input  logic [7:0] code,
   output op_e        op
);

   // highest set bit wins: later iterations overwrite earlier ones
   always_comb begin
      op = OP_NOP;
      for (int i = 0; i < 8; i++) begin
         if (code[i]) op = op_e'(4'(i + 1));
      end
   end

   always_comb begin
      // R2: an all-zero byte never decodes to an operation
      a_nop_zero_r2: assert (code != 8'h00 || op == OP_NOP);
   end

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
   parameter int LONG_CYC  = 886,
   parameter int SHORT_CYC = 22
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic long_sel,
   output logic busy
);

   localparam int CW = $clog2(LONG_CYC + 1);

   logic [CW-1:0] cnt;

   initial begin
      a_cfg_cycles: assert (SHORT_CYC >= 1 && LONG_CYC >= SHORT_CYC)
         else $error("busy window parameters out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= long_sel ? CW'(LONG_CYC) : CW'(SHORT_CYC);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // R12: busy follows an accepted transfer in the next cycle
   p_busy_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R13: the owner never starts a transfer while busy
   p_start_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/lcd_clear_seq.sv
module lcd_clear_seq #(
   parameter int DEPTH = 80,
   parameter int AW    = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          we,
   output logic [AW-1:0] addr
);

   logic          active;
   logic [AW-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (start) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (active) begin
         if (idx == AW'(DEPTH - 1))
            active <= 1'b0;
         else
            idx <= idx + 1'b1;
      end
   end

   assign we   = active;
   assign addr = idx;

   // R3: sweep stays inside the display RAM
   p_clear_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (idx < AW'(DEPTH)));

   // R3: sweep is not cut short before the last address
   p_clear_cont_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && idx != AW'(DEPTH - 1)) |=> active);

endmodule

// File: rtl/lcd_instr_exec.sv
module lcd_instr_exec
   import lcd_exec_pkg::*;
#(
   parameter int   DD_DEPTH   = 80,
   parameter int   CG_DEPTH   = 64,
   parameter int   BUSY_LONG  = 886,
   parameter int   BUSY_SHORT = 22,
   localparam int  DD_AW      = $clog2(DD_DEPTH),
   localparam int  CG_AW      = $clog2(CG_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_valid,
   input  logic             host_rs,
   input  logic             host_rw,
   input  logic [7:0]       host_byte,
   output logic             busy,
   output logic [DD_AW-1:0] ac,
   output logic             target_cg,
   output logic             disp_on,
   output logic             cursor_on,
   output logic             blink_on,
   output logic             entry_inc,
   output logic             entry_shift,
   output logic             bus_8bit,
   output logic             two_line,
   output logic             font_tall,
   output logic [DD_AW-1:0] shift_ofs,
   output logic             dd_we,
   output logic             dd_re,
   output logic [DD_AW-1:0] dd_addr,
   output logic [7:0]       dd_wdata,
   output logic             cg_we,
   output logic             cg_re,
   output logic [CG_AW-1:0] cg_addr,
   output logic [7:0]       cg_wdata
);

   localparam int LINE_LEN = DD_DEPTH / 2;

   initial begin
      a_cfg_depth: assert (DD_DEPTH <= 128 && DD_DEPTH >= 2 && CG_DEPTH <= 64
                           && DD_AW >= CG_AW && BUSY_LONG >= DD_DEPTH)
         else $error("depth parameters out of range");
   end

   // ---------------- decode and acceptance ----------------
   op_e  op;
   logic acc_data, acc_instr, start, long_sel, clr_start;

   lcd_op_decode u_dec (.code(host_byte), .op(op));

   assign acc_data  = host_valid && !busy && host_rs;
   assign acc_instr = host_valid && !busy && !host_rs && !host_rw && (op != OP_NOP);
   assign start     = acc_data || acc_instr;
   assign long_sel  = acc_instr && (op == OP_CLEAR || op == OP_HOME);
   assign clr_start = acc_instr && (op == OP_CLEAR);

   lcd_busy_timer #(.LONG_CYC(BUSY_LONG), .SHORT_CYC(BUSY_SHORT)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(start), .long_sel(long_sel), .busy(busy));

   logic             clr_we;
   logic [DD_AW-1:0] clr_addr;

   lcd_clear_seq #(.DEPTH(DD_DEPTH), .AW(DD_AW)) u_clr (
      .clk(clk), .rst_n(rst_n), .start(clr_start), .we(clr_we), .addr(clr_addr));

   // ---------------- display address load variant ----------------
   logic [DD_AW-1:0] dd_load;

   if (DD_DEPTH == (1 << DD_AW)) begin : g_dd_pow2
      assign dd_load = host_byte[DD_AW-1:0];
   end else begin : g_dd_mod
      logic [7:0] raw;
      assign raw     = {1'b0, host_byte[6:0]};
      assign dd_load = DD_AW'(raw % 8'(DD_DEPTH));
   end

   // ---------------- stepping helpers ----------------
   logic [7:0] ac_mod, ofs_mod;
   assign ac_mod  = target_cg ? 8'(CG_DEPTH) : 8'(DD_DEPTH);
   assign ofs_mod = two_line  ? 8'(LINE_LEN) : 8'(DD_DEPTH);

   // ---------------- state ----------------
   logic             dd_we_q, dd_re_q, cg_we_q, cg_re_q;
   logic [DD_AW-1:0] ram_addr_q;
   logic [7:0]       wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ac          <= '0;
         target_cg   <= 1'b0;
         disp_on     <= 1'b0;
         cursor_on   <= 1'b0;
         blink_on    <= 1'b0;
         entry_inc   <= 1'b1;
         entry_shift <= 1'b0;
         bus_8bit    <= 1'b1;
         two_line    <= 1'b0;
         font_tall   <= 1'b0;
         shift_ofs   <= '0;
         dd_we_q     <= 1'b0;
         dd_re_q     <= 1'b0;
         cg_we_q     <= 1'b0;
         cg_re_q     <= 1'b0;
         ram_addr_q  <= '0;
         wdata_q     <= '0;
      end else begin
         dd_we_q <= 1'b0;
         dd_re_q <= 1'b0;
         cg_we_q <= 1'b0;
         cg_re_q <= 1'b0;
         if (acc_data) begin
            ram_addr_q <= ac;
            wdata_q    <= host_byte;
            dd_we_q    <= !target_cg && !host_rw;
            dd_re_q    <= !target_cg &&  host_rw;
            cg_we_q    <=  target_cg && !host_rw;
            cg_re_q    <=  target_cg &&  host_rw;
            ac         <= DD_AW'(step_mod(8'(ac), entry_inc, ac_mod));
            if (entry_shift && !target_cg)
               shift_ofs <= DD_AW'(step_mod(8'(shift_ofs), entry_inc, ofs_mod));
         end else if (acc_instr) begin
            case (op)
               OP_CLEAR, OP_HOME: begin
                  ac        <= '0;
                  target_cg <= 1'b0;
                  shift_ofs <= '0;
               end
               OP_ENTRY: begin
                  entry_inc   <= host_byte[1];
                  entry_shift <= host_byte[0];
               end
               OP_DISP: begin
                  disp_on   <= host_byte[2];
                  cursor_on <= host_byte[1];
                  blink_on  <= host_byte[0];
               end
               OP_SHIFT: begin
                  if (host_byte[3])
                     shift_ofs <= DD_AW'(step_mod(8'(shift_ofs), !host_byte[2], ofs_mod));
                  else
                     ac <= DD_AW'(step_mod(8'(ac), host_byte[2], ac_mod));
               end
               OP_FUNC: begin
                  bus_8bit  <= host_byte[4];
                  two_line  <= host_byte[3];
                  font_tall <= host_byte[2];
               end
               OP_SETCG: begin
                  target_cg <= 1'b1;
                  ac        <= DD_AW'(host_byte[CG_AW-1:0]);
               end
               OP_SETDD: begin
                  target_cg <= 1'b0;
                  ac        <= dd_load;
               end
               default: ;
            endcase
         end
      end
   end

   // ---------------- RAM ports ----------------
   assign dd_we    = dd_we_q || clr_we;
   assign dd_re    = dd_re_q;
   assign dd_addr  = clr_we ? clr_addr : ram_addr_q;
   assign dd_wdata = clr_we ? BLANK_CODE : wdata_q;
   assign cg_we    = cg_we_q;
   assign cg_re    = cg_re_q;
   assign cg_addr  = ram_addr_q[CG_AW-1:0];
   assign cg_wdata = wdata_q;

   // R7: at most one RAM strobe per cycle
   p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dd_we, dd_re, cg_we, cg_re}));

   // R13: nothing visible changes across a busy cycle
   p_ignore_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(ac) && $stable(target_cg) && $stable(shift_ofs)
                && $stable(disp_on) && $stable(entry_inc) && $stable(two_line)));

   // R6: a display-RAM counter never leaves the RAM
   p_ac_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !target_cg |-> (ac < DD_AW'(DD_DEPTH)));

   // R11: the shift offset stays inside the display area
   p_ofs_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      shift_ofs < DD_AW'(DD_DEPTH));

   // R12: a data transfer strobe appears only after an accepted transfer
   p_strobe_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (dd_re || cg_we || cg_re) |-> busy);

endmodule

// File: tb/test_lcd_instr_exec.sv
`timescale 1ns/1ps
module test_lcd_instr_exec;

   localparam int DD_DEPTH   = 80;
   localparam int CG_DEPTH   = 64;
   localparam int BUSY_LONG  = 90;
   localparam int BUSY_SHORT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_valid = 1'b0, host_rs = 1'b0, host_rw = 1'b0;
   logic [7:0] host_byte = 8'h00;
   logic       busy, target_cg, disp_on, cursor_on, blink_on, entry_inc, entry_shift;
   logic       bus_8bit, two_line, font_tall, dd_we, dd_re, cg_we, cg_re;
   logic [6:0] ac, shift_ofs, dd_addr;
   logic [5:0] cg_addr;
   logic [7:0] dd_wdata, cg_wdata;

   always #2 clk = ~clk;

   lcd_instr_exec #(.DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH),
                    .BUSY_LONG(BUSY_LONG), .BUSY_SHORT(BUSY_SHORT)) i_lcd_instr_exec (
      .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_rs(host_rs),
      .host_rw(host_rw), .host_byte(host_byte), .busy(busy), .ac(ac),
      .target_cg(target_cg), .disp_on(disp_on), .cursor_on(cursor_on),
      .blink_on(blink_on), .entry_inc(entry_inc), .entry_shift(entry_shift),
      .bus_8bit(bus_8bit), .two_line(two_line), .font_tall(font_tall),
      .shift_ofs(shift_ofs), .dd_we(dd_we), .dd_re(dd_re), .dd_addr(dd_addr),
      .dd_wdata(dd_wdata), .cg_we(cg_we), .cg_re(cg_re), .cg_addr(cg_addr),
      .cg_wdata(cg_wdata));

   int n_tests = 0;
   int n_fail  = 0;
   int dd_wr_cnt = 0;
   logic [7:0] dd_mem [0:DD_DEPTH-1];

   // model of the display RAM, fed from the port
   always @(negedge clk) begin
      if (rst_n && dd_we) begin
         dd_wr_cnt++;
         if (dd_addr < 7'(DD_DEPTH)) dd_mem[dd_addr] = dd_wdata;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic send(input logic rs, input logic rw, input logic [7:0] b);
      @(negedge clk);
      while (busy) @(negedge clk);
      host_valid = 1'b1; host_rs = rs; host_rw = rw; host_byte = b;
      @(posedge clk); #1;
      host_valid = 1'b0;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(posedge clk); #1;
      end
   endtask

   // {rs, rw, byte, exp ac, exp ofs, exp target, exp strobes {ddwe,ddre,cgwe,cgre}, exp strobe addr, req}
   localparam int NV = 30;
   localparam logic [39:0] VEC [0:NV-1] = '{
      {1'b0,1'b0,8'h06, 7'd0, 7'd0, 1'b0,4'b0000,7'd0, 4'd5},   // R5 entry inc
      {1'b0,1'b0,8'h85, 7'd5, 7'd0, 1'b0,4'b0000,7'd0, 4'd6},   // R6 DD address
      {1'b1,1'b0,8'h41, 7'd6, 7'd0, 1'b0,4'b1000,7'd5, 4'd7},   // R7 write, step up
      {1'b1,1'b0,8'h42, 7'd7, 7'd0, 1'b0,4'b1000,7'd6, 4'd7},
      {1'b0,1'b0,8'h04, 7'd7, 7'd0, 1'b0,4'b0000,7'd0, 4'd5},   // entry dec
      {1'b1,1'b0,8'h43, 7'd6, 7'd0, 1'b0,4'b1000,7'd7, 4'd7},   // step down
      {1'b0,1'b0,8'h10, 7'd5, 7'd0, 1'b0,4'b0000,7'd0, 4'd10},  // R10 cursor left
      {1'b0,1'b0,8'h14, 7'd6, 7'd0, 1'b0,4'b0000,7'd0, 4'd10},  // cursor right
      {1'b0,1'b0,8'h18, 7'd6, 7'd1, 1'b0,4'b0000,7'd0, 4'd10},  // display left
      {1'b0,1'b0,8'h1C, 7'd6, 7'd0, 1'b0,4'b0000,7'd0, 4'd10},  // display right
      {1'b0,1'b0,8'h1C, 7'd6, 7'd79,1'b0,4'b0000,7'd0, 4'd11},  // R11 wrap 0 -> 79
      {1'b0,1'b0,8'h7F, 7'd63,7'd79,1'b1,4'b0000,7'd0, 4'd6},   // CG address 63
      {1'b0,1'b0,8'h06, 7'd63,7'd79,1'b1,4'b0000,7'd0, 4'd5},
      {1'b1,1'b0,8'h1F, 7'd0, 7'd79,1'b1,4'b0010,7'd63,4'd7},   // CG wrap 63 -> 0
      {1'b1,1'b1,8'h00, 7'd1, 7'd79,1'b1,4'b0001,7'd0, 4'd8},   // R8 CG read
      {1'b0,1'b0,8'hC0, 7'd64,7'd79,1'b0,4'b0000,7'd0, 4'd6},
      {1'b0,1'b0,8'hFF, 7'd47,7'd79,1'b0,4'b0000,7'd0, 4'd6},   // 127 mod 80
      {1'b0,1'b0,8'hCF, 7'd79,7'd79,1'b0,4'b0000,7'd0, 4'd6},
      {1'b1,1'b0,8'h55, 7'd0, 7'd79,1'b0,4'b1000,7'd79,4'd7},   // DD wrap 79 -> 0
      {1'b0,1'b0,8'h04, 7'd0, 7'd79,1'b0,4'b0000,7'd0, 4'd5},
      {1'b1,1'b1,8'h00, 7'd79,7'd79,1'b0,4'b0100,7'd0, 4'd8},   // DD read, wrap 0 -> 79
      {1'b0,1'b0,8'h38, 7'd79,7'd79,1'b0,4'b0000,7'd0, 4'd5},   // two-line
      {1'b0,1'b0,8'h02, 7'd0, 7'd0, 1'b0,4'b0000,7'd0, 4'd4},   // R4 home
      {1'b0,1'b0,8'h07, 7'd0, 7'd0, 1'b0,4'b0000,7'd0, 4'd5},
      {1'b1,1'b0,8'h61, 7'd1, 7'd1, 1'b0,4'b1000,7'd0, 4'd9},   // R9 shift on write
      {1'b0,1'b0,8'h05, 7'd1, 7'd1, 1'b0,4'b0000,7'd0, 4'd5},
      {1'b1,1'b0,8'h62, 7'd0, 7'd0, 1'b0,4'b1000,7'd1, 4'd9},
      {1'b1,1'b0,8'h63, 7'd79,7'd39,1'b0,4'b1000,7'd0, 4'd11},  // wrap 0 -> 39
      {1'b0,1'b0,8'h18, 7'd79,7'd0, 1'b0,4'b0000,7'd0, 4'd11},  // wrap 39 -> 0
      {1'b0,1'b0,8'h00, 7'd79,7'd0, 1'b0,4'b0000,7'd0, 4'd2}    // R2 null byte
   };

   initial begin : watchdog
      #(4 * 100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      int n, base;
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] = 8'hFF;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 ac", ac, 0);
      check("R1 busy", busy, 0);
      check("R1 ofs", shift_ofs, 0);
      check("R1 flags", {target_cg, disp_on, cursor_on, blink_on, entry_inc,
                         entry_shift, bus_8bit, two_line, font_tall}, 9'b000010100);
      check("R1 strobes", {dd_we, dd_re, cg_we, cg_re}, 0);

      // vector walk
      for (int v = 0; v < NV; v++) begin
         logic [39:0] e;
         string t;
         e = VEC[v];
         send(e[39], e[38], e[37:30]);
         t = $sformatf("R%0d vec%0d", e[3:0], v);
         check({t, " ac"}, ac, e[29:23]);
         check({t, " ofs"}, shift_ofs, e[22:16]);
         check({t, " tgt"}, target_cg, e[15]);
         check({t, " strobes"}, {dd_we, dd_re, cg_we, cg_re}, e[14:11]);
         if (e[14] || e[13]) check({t, " dd_addr"}, dd_addr, e[10:4]);
         if (e[12] || e[11]) check({t, " cg_addr"}, cg_addr, e[9:4]);
         if (e[14]) check({t, " dd_wdata"}, dd_wdata, e[37:30]);
         if (e[12]) check({t, " cg_wdata"}, cg_wdata, e[37:30]);
      end
      check("R2 null byte no busy", busy, 0);

      // R5 mode fields
      send(1'b0, 1'b0, 8'h0F);
      check("R5 disp/cursor/blink", {disp_on, cursor_on, blink_on}, 3'b111);
      send(1'b0, 1'b0, 8'h0A);
      check("R5 disp/cursor/blink", {disp_on, cursor_on, blink_on}, 3'b010);
      send(1'b0, 1'b0, 8'h24);
      check("R5 bus/lines/font", {bus_8bit, two_line, font_tall}, 3'b001);

      // R12 short busy window
      send(1'b0, 1'b0, 8'h06);
      send(1'b1, 1'b0, 8'h30);
      busy_len(n);
      check("R12 short busy", n, BUSY_SHORT);

      // R13 transfer during busy is dropped
      send(1'b0, 1'b0, 8'h85);
      @(negedge clk);
      host_valid = 1'b1; host_rs = 1'b0; host_rw = 1'b0; host_byte = 8'hC9;
      @(posedge clk); #1;
      host_valid = 1'b0;
      check("R13 strobe while busy", {dd_we, dd_re, cg_we, cg_re}, 0);
      busy_len(n);
      check("R13 ac kept", ac, 5);
      @(negedge clk);
      host_valid = 1'b1; host_rs = 1'b0; host_rw = 1'b1; host_byte = 8'h01;
      @(posedge clk); #1;
      host_valid = 1'b0;
      check("R13 status no busy", busy, 0);
      check("R13 status ac", ac, 5);

      // R4 home keeps RAM and takes the long window
      send(1'b1, 1'b0, 8'h39);               // writes address 5
      send(1'b0, 1'b0, 8'h1C);               // offset -> 79
      base = dd_wr_cnt;
      send(1'b0, 1'b0, 8'h02);
      busy_len(n);
      check("R4 home busy", n, BUSY_LONG);
      check("R4 home ac", ac, 0);
      check("R4 home ofs", shift_ofs, 0);
      check("R4 home no writes", dd_wr_cnt - base, 0);
      check("R4 ram kept", dd_mem[5], 8'h39);

      // R3 clear
      send(1'b0, 1'b0, 8'h45);               // CG target
      send(1'b0, 1'b0, 8'h18);               // offset 1
      base = dd_wr_cnt;
      send(1'b0, 1'b0, 8'h01);
      busy_len(n);
      check("R3 clear busy", n, BUSY_LONG);
      check("R3 clear write count", dd_wr_cnt - base, DD_DEPTH);
      begin
         int bad;
         bad = 0;
         for (int i = 0; i < DD_DEPTH; i++) if (dd_mem[i] != 8'h20) bad++;
         check("R3 clear blanks", bad, 0);
      end
      check("R3 clear ac", ac, 0);
      check("R3 clear ofs", shift_ofs, 0);
      check("R3 clear target", target_cg, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule